// File: doc/BRIEF.md
# Single-Bit Boolean Execution Unit

This unit carries out one-bit instructions that work on an internal carry flag and on one addressed bit. A start pulse launches an operation. With it come an operation code, a flag that sends clear, set or complement to the carry or to the addressed bit, a flag for the short or extended address form, a flag for the binary or source execution mode, and the class of region the bit lives in. The addressed bit is reached through a simple bit bus. This bus has a combinational read port (`bus_rdata` shows the bit at `bus_addr` in the same cycle) and a write strobe. The carry is held inside the unit.

The time an operation takes is counted in states, one clock cycle each. It depends on four things: whether the operation writes the bit or only reads it, the address form, the execution mode, and whether the region is an I/O port or a peripheral register. `done` goes high in the final state. The new carry is visible from the cycle after `done`. Fetch, decode and address computation happen upstream.

Top module: `bitop_unit`

## Requirements
- R1: After a synchronous reset, `carry`, `busy`, `done`, `bus_re` and `bus_we` are all 0.
- R2: With `on_carry`=1, op 0 (clear), op 1 (set) and op 2 (complement) make the carry 0, 1 or its inverse. They take 1 state and make no bus access.
- R3: With `on_carry`=0, ops 0, 1 and 2 write 0, 1 or the inverse of the bit read back to the addressed bit. The write is one `bus_we` pulse in the final state, with the value on `bus_wdata`.
- R4: Op 3 sets carry to carry AND bit, op 4 to carry AND NOT bit, op 5 to carry OR bit, and op 6 to carry OR NOT bit.
- R5: Op 7 copies the addressed bit into the carry. Op 8 writes the carry into the addressed bit and leaves the carry unchanged.
- R6: In the short form (`ext_form`=0), ops 3 to 7 take 1 state and bit-writing ops (0 to 2 on the bit, and 8) take 2 states. Both figures apply to region 0 (internal RAM).
- R7: In the extended form, read-only ops take 3 states in binary mode (`src_mode`=0) and 2 in source mode. Bit-writing ops take 4 states in binary mode and 3 in source mode.
- R8: Region 1 (I/O port) adds 1 state to read-only ops and 2 to bit-writing ops. Regions 2 and 3 (peripheral register) add 2 and 3.
- R9: `done` is high for exactly one cycle, L cycles after the cycle in which start is accepted, where L is the state count. `busy` is high from the first state to the final state.
- R10: Every op that touches the bit pulses `bus_re` once, in the first state, with `bus_addr` equal to the captured `bit_addr`. The carry changes only on the edge that ends a final state.
- R11: A start pulse while `busy` is high is ignored.
- R12: A start with an op code of 9 to 15 is ignored: no `busy`, no `done`, no change to carry or memory.
- R13: A reset during an operation returns the unit to idle and clears the carry, and no write or `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch pulse, accepted when idle |
| op | input | 4 | Operation code, 0 to 8 |
| on_carry | input | 1 | Clear/set/complement target: 1 = carry, 0 = addressed bit |
| ext_form | input | 1 | 1 = extended address form |
| src_mode | input | 1 | 1 = source mode, 0 = binary mode |
| region | input | 2 | 0 RAM, 1 I/O port, 2 or 3 peripheral register |
| bit_addr | input | ADDR_W | Address of the operand bit |
| bus_addr | output | ADDR_W | Bit bus address |
| bus_re | output | 1 | Bit bus read strobe |
| bus_we | output | 1 | Bit bus write strobe |
| bus_wdata | output | 1 | Bit bus write value |
| bus_rdata | input | 1 | Bit bus read value, combinational from `bus_addr` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final state of an operation |
| carry | output | 1 | Carry flag |

## Verification
The bound checker holds the protocol rules on every cycle:
- `done` lasts one cycle and only while `busy`.
- A write appears only with `done`, and a read never shares a cycle with a write.
- The carry holds except after a final state.
- `busy` starts only after a start pulse.
- Reset leaves the unit idle with a clear carry.

Only the bench's scenarios can show the exact state count for each combination of operation, form, mode and region. The same holds for the Boolean results against a model memory, the dropped start pulses and the cancelled operation.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

   typedef enum logic [3:0] {
      OP_CLR    = 4'd0,
      OP_SET    = 4'd1,
      OP_CPL    = 4'd2,
      OP_AND    = 4'd3,
      OP_ANDN   = 4'd4,
      OP_OR     = 4'd5,
      OP_ORN    = 4'd6,
      OP_TOCY   = 4'd7,
      OP_FROMCY = 4'd8
   } bitop_e;

   localparam logic [3:0] OP_MAX = 4'd8;

   // true when the operation writes the addressed bit
   function automatic logic op_writes_bit(bitop_e o, logic oc);
      return ((o == OP_CLR || o == OP_SET || o == OP_CPL) && !oc) || (o == OP_FROMCY);
   endfunction

   // true when the operation touches the addressed bit at all
   function automatic logic op_uses_bus(bitop_e o, logic oc);
      return !((o == OP_CLR || o == OP_SET || o == OP_CPL) && oc);
   endfunction

   // true when the carry is the destination
   function automatic logic op_targets_carry(bitop_e o, logic oc);
      return !op_writes_bit(o, oc);
   endfunction

   function automatic int maxi(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bitop_latency.sv
module bitop_latency
   import bitop_pkg::*;
#(
   parameter int CNT_W         = 3,
   parameter int CY_STATES     = 1,
   parameter int RD_SHORT      = 1,
   parameter int RD_EXT_BIN    = 3,
   parameter int RD_EXT_SRC    = 2,
   parameter int WR_SHORT      = 2,
   parameter int WR_EXT_BIN    = 4,
   parameter int WR_EXT_SRC    = 3,
   parameter int PORT_RD_EXTRA = 1,
   parameter int PERI_RD_EXTRA = 2,
   parameter int PORT_WR_EXTRA = 2,
   parameter int PERI_WR_EXTRA = 3
) (
   input  logic             writer,
   input  logic             uses_bus,
   input  logic             ext,
   input  logic             src,
   input  logic [1:0]       rg,
   output logic [CNT_W-1:0] n_states
);

   localparam int N_RG = 4;

   logic [CNT_W-1:0] rd_add [N_RG];
   logic [CNT_W-1:0] wr_add [N_RG];
   logic [CNT_W-1:0] base;

   // region 0 adds nothing, region 1 is a port, regions 2 and 3 are peripherals
   for (genvar g = 0; g < N_RG; g++) begin : g_region
      localparam int RA = (g == 0) ? 0 : ((g == 1) ? PORT_RD_EXTRA : PERI_RD_EXTRA);
      localparam int WA = (g == 0) ? 0 : ((g == 1) ? PORT_WR_EXTRA : PERI_WR_EXTRA);
      assign rd_add[g] = CNT_W'(RA);
      assign wr_add[g] = CNT_W'(WA);
   end

   always_comb begin
      if (writer)
         base = ext ? (src ? CNT_W'(WR_EXT_SRC) : CNT_W'(WR_EXT_BIN)) : CNT_W'(WR_SHORT);
      else
         base = ext ? (src ? CNT_W'(RD_EXT_SRC) : CNT_W'(RD_EXT_BIN)) : CNT_W'(RD_SHORT);
      if (!uses_bus)
         n_states = CNT_W'(CY_STATES);
      else
         n_states = base + (writer ? wr_add[rg] : rd_add[rg]);
   end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
   import bitop_pkg::*;
(
   input  bitop_e op,
   input  logic   on_carry,
   input  logic   cy,
   input  logic   bv,
   output logic   cy_nx,
   output logic   bit_nx
);

   logic dst_now;

   assign dst_now = on_carry ? cy : bv;

   always_comb begin
      cy_nx  = cy;
      bit_nx = bv;
      unique case (op)
         OP_CLR:    begin if (on_carry) cy_nx = 1'b0;     else bit_nx = 1'b0;     end
         OP_SET:    begin if (on_carry) cy_nx = 1'b1;     else bit_nx = 1'b1;     end
         OP_CPL:    begin if (on_carry) cy_nx = ~dst_now; else bit_nx = ~dst_now; end
         OP_AND:    cy_nx  = cy & bv;
         OP_ANDN:   cy_nx  = cy & ~bv;
         OP_OR:     cy_nx  = cy | bv;
         OP_ORN:    cy_nx  = cy | ~bv;
         OP_TOCY:   cy_nx  = bv;
         OP_FROMCY: bit_nx = cy;
         default:   begin cy_nx = cy; bit_nx = bv; end
      endcase
   end

endmodule

// File: rtl/bitop_seq.sv
module bitop_seq #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             launch,
   input  logic [CNT_W-1:0] n_states,
   output logic             busy,
   output logic             first,
   output logic             last
);

   typedef enum logic {S_IDLE, S_RUN} seq_e;

   seq_e             st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= S_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (launch) begin
               st  <= S_RUN;
               cnt <= CNT_W'(1);
            end
            S_RUN: if (cnt == n_states) begin
               st  <= S_IDLE;
               cnt <= '0;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy  = (st == S_RUN);
   assign first = busy && (cnt == CNT_W'(1));
   assign last  = busy && (cnt == n_states);

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int CY_STATES     = 1,
   parameter int RD_SHORT      = 1,
   parameter int RD_EXT_BIN    = 3,
   parameter int RD_EXT_SRC    = 2,
   parameter int WR_SHORT      = 2,
   parameter int WR_EXT_BIN    = 4,
   parameter int WR_EXT_SRC    = 3,
   parameter int PORT_RD_EXTRA = 1,
   parameter int PERI_RD_EXTRA = 2,
   parameter int PORT_WR_EXTRA = 2,
   parameter int PERI_WR_EXTRA = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [3:0]        op,
   input  logic              on_carry,
   input  logic              ext_form,
   input  logic              src_mode,
   input  logic [1:0]        region,
   input  logic [ADDR_W-1:0] bit_addr,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_re,
   output logic              bus_we,
   output logic              bus_wdata,
   input  logic              bus_rdata,
   output logic              busy,
   output logic              done,
   output logic              carry
);

   localparam int RD_MAX = maxi(maxi(RD_EXT_BIN, RD_EXT_SRC), RD_SHORT)
                           + maxi(PORT_RD_EXTRA, PERI_RD_EXTRA);
   localparam int WR_MAX = maxi(maxi(WR_EXT_BIN, WR_EXT_SRC), WR_SHORT)
                           + maxi(PORT_WR_EXTRA, PERI_WR_EXTRA);
   localparam int MAX_ST = maxi(maxi(RD_MAX, WR_MAX), CY_STATES);
   localparam int CNT_W  = $clog2(MAX_ST + 1);

   // elaboration-time parameter checks
   if (ADDR_W < 1) begin : g_bad_addr
      $error("bitop_unit: ADDR_W must be at least 1");
   end
   if (CY_STATES < 1 || RD_SHORT < 1) begin : g_bad_min
      $error("bitop_unit: every operation needs at least one state");
   end
   if (WR_SHORT < 2 || WR_EXT_SRC < 2 || WR_EXT_BIN < 2) begin : g_bad_wr
      $error("bitop_unit: bit writes need a read state before the write state");
   end
   if (PORT_RD_EXTRA < 0 || PERI_RD_EXTRA < 0 || PORT_WR_EXTRA < 0 || PERI_WR_EXTRA < 0) begin : g_bad_extra
      $error("bitop_unit: region penalties must not be negative");
   end

   bitop_e            op_q;
   logic              oc_q, ext_q, src_q;
   logic [1:0]        rg_q;
   logic [ADDR_W-1:0] addr_q;
   logic              bval_q;
   logic              carry_q;

   logic              launch, first, last;
   logic              writer, uses_bus, to_carry;
   logic              bval, cy_nx, bit_nx;
   logic [CNT_W-1:0]  n_states;

   assign launch = start && !busy && (op <= OP_MAX);

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q   <= OP_CLR;
         oc_q   <= 1'b0;
         ext_q  <= 1'b0;
         src_q  <= 1'b0;
         rg_q   <= '0;
         addr_q <= '0;
      end else if (launch) begin
         op_q   <= bitop_e'(op);
         oc_q   <= on_carry;
         ext_q  <= ext_form;
         src_q  <= src_mode;
         rg_q   <= region;
         addr_q <= bit_addr;
      end
   end

   assign writer   = op_writes_bit(op_q, oc_q);
   assign uses_bus = op_uses_bus(op_q, oc_q);
   assign to_carry = op_targets_carry(op_q, oc_q);

   bitop_latency #(
      .CNT_W(CNT_W), .CY_STATES(CY_STATES),
      .RD_SHORT(RD_SHORT), .RD_EXT_BIN(RD_EXT_BIN), .RD_EXT_SRC(RD_EXT_SRC),
      .WR_SHORT(WR_SHORT), .WR_EXT_BIN(WR_EXT_BIN), .WR_EXT_SRC(WR_EXT_SRC),
      .PORT_RD_EXTRA(PORT_RD_EXTRA), .PERI_RD_EXTRA(PERI_RD_EXTRA),
      .PORT_WR_EXTRA(PORT_WR_EXTRA), .PERI_WR_EXTRA(PERI_WR_EXTRA)
   ) u_lat (
      .writer(writer), .uses_bus(uses_bus), .ext(ext_q), .src(src_q),
      .rg(rg_q), .n_states(n_states)
   );

   bitop_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst(rst), .launch(launch), .n_states(n_states),
      .busy(busy), .first(first), .last(last)
   );

   // the bit is sampled in the first state and reused by later states
   always_ff @(posedge clk) begin
      if (rst)                   bval_q <= 1'b0;
      else if (first && uses_bus) bval_q <= bus_rdata;
   end

   assign bval = first ? bus_rdata : bval_q;

   bitop_alu u_alu (
      .op(op_q), .on_carry(oc_q), .cy(carry_q), .bv(bval),
      .cy_nx(cy_nx), .bit_nx(bit_nx)
   );

   always_ff @(posedge clk) begin
      if (rst)                  carry_q <= 1'b0;
      else if (last && to_carry) carry_q <= cy_nx;
   end

   assign bus_addr  = addr_q;
   assign bus_re    = first && uses_bus;
   assign bus_we    = last && writer;
   assign bus_wdata = bit_nx;
   assign done      = last;
   assign carry     = carry_q;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk (
   input logic clk,
   input logic rst,
   input logic start,
   input logic busy,
   input logic done,
   input logic carry,
   input logic bus_re,
   input logic bus_we
);

   logic past_ok = 1'b0;

   always_ff @(posedge clk) past_ok <= 1'b1;

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R9
   done_busy_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> busy);

   // R3
   we_final_chk: assert property (@(posedge clk) disable iff (rst)
      bus_we |-> done);

   // R10
   rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(bus_re && bus_we));

   // R10
   carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(rst) && !$past(done)) |-> $stable(carry));

   // R11
   busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $rose(busy)) |-> $past(start));

   // R13
   reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(rst)) |-> (!busy && !carry && !done));

endmodule

bind bitop_unit bitop_unit_chk u_chk (
   .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
   .carry(carry), .bus_re(bus_re), .bus_we(bus_we)
);

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [3:0]    op = '0;
   logic          on_carry = 1'b0, ext_form = 1'b0, src_mode = 1'b0;
   logic [1:0]    region = '0;
   logic [AW-1:0] bit_addr = '0;
   logic [AW-1:0] bus_addr;
   logic          bus_re, bus_we, bus_wdata, bus_rdata, busy, done, carry;

   always #(CLK_PERIOD/2) clk = ~clk;

   bitop_unit #(.ADDR_W(AW)) u_bitop_unit (
      .clk(clk), .rst(rst), .start(start), .op(op), .on_carry(on_carry),
      .ext_form(ext_form), .src_mode(src_mode), .region(region),
      .bit_addr(bit_addr), .bus_addr(bus_addr), .bus_re(bus_re),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .carry(carry)
   );

   // bit memory behind the bus
   logic mem   [256];
   logic m_mem [256];
   logic m_cy;
   assign bus_rdata = mem[bus_addr];
   always @(posedge clk) if (bus_we) mem[bus_addr] <= bus_wdata;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0, bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input int req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL R%0d: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   typedef struct {
      int       exp_cyc;
      int       lat_req;
      int       res_req;
      bit       exp_we;
      bit       exp_wdata;
      bit       exp_cy;
      int       exp_re;
      int       addr;
   } item_t;

   item_t sbq[$];
   int    re_cnt = 0;
   bit    pend = 1'b0;
   bit    pend_cy;
   int    pend_req;

   // monitor: compares results against the scoreboard at the falling edge
   always @(negedge clk) begin
      if (pend) begin
         chk(carry == pend_cy, pend_req, carry, pend_cy);
         pend = 1'b0;
      end
      if (!rst) begin
         if (bus_re) begin
            re_cnt++;
            if (sbq.size() != 0) chk(int'(bus_addr) == sbq[0].addr, 10, bus_addr, sbq[0].addr); // R10
         end
         if (bus_we && !done) chk(1'b0, 3, 1, 0); // R3: write outside final state
         if (done) begin
            if (sbq.size() == 0) begin
               chk(1'b0, 11, 1, 0); // R11/R12/R13: unexpected done
            end else begin
               item_t it;
               it = sbq.pop_front();
               chk(cyc == it.exp_cyc, it.lat_req, cyc, it.exp_cyc);
               chk(bus_we == it.exp_we, it.res_req, bus_we, it.exp_we);
               if (it.exp_we) chk(bus_wdata == it.exp_wdata, it.res_req, bus_wdata, it.exp_wdata);
               chk(re_cnt == it.exp_re, 10, re_cnt, it.exp_re); // R10
               pend     = 1'b1;
               pend_cy  = it.exp_cy;
               pend_req = it.res_req;
            end
            re_cnt = 0;
         end
      end
   end

   function automatic int exp_states(int o, int oc, int ex, int sr, int rg);
      bit wr;
      int base, add;
      if (o <= 2 && oc != 0) return 1;
      wr   = (o <= 2) || (o == 8);
      base = wr ? (ex != 0 ? (sr != 0 ? 3 : 4) : 2) : (ex != 0 ? (sr != 0 ? 2 : 3) : 1);
      add  = (rg == 0) ? 0 : (rg == 1) ? (wr ? 2 : 1) : (wr ? 3 : 2);
      return base + add;
   endfunction

   // driver: computes the expected outcome, pushes it, launches the op
   task automatic run_op(input int o, input int oc, input int ex, input int sr,
                         input int rg, input int adr, input bit inject);
      item_t it;
      bit b, cy, nb;
      int L;
      b  = m_mem[adr];
      cy = m_cy;
      nb = b;
      L  = exp_states(o, oc, ex, sr, rg);
      case (o)
         0: if (oc != 0) cy = 1'b0; else nb = 1'b0;
         1: if (oc != 0) cy = 1'b1; else nb = 1'b1;
         2: if (oc != 0) cy = ~cy;  else nb = ~b;
         3: cy = cy & b;
         4: cy = cy & ~b;
         5: cy = cy | b;
         6: cy = cy | ~b;
         7: cy = b;
         default: nb = cy;
      endcase
      it.exp_cyc   = cyc + L;
      it.lat_req   = (rg != 0 && !(o <= 2 && oc != 0)) ? 8 : (ex != 0 ? 7 : 6);
      it.res_req   = (o <= 2) ? (oc != 0 ? 2 : 3) : (o <= 6 ? 4 : 5);
      it.exp_we    = (o <= 2 && oc == 0) || (o == 8);
      it.exp_wdata = nb;
      it.exp_cy    = cy;
      it.exp_re    = (o <= 2 && oc != 0) ? 0 : 1;
      it.addr      = adr;
      sbq.push_back(it);
      op = 4'(o); on_carry = oc[0]; ext_form = ex[0]; src_mode = sr[0];
      region = 2'(rg); bit_addr = AW'(adr); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (inject) begin
         // R11: second start while busy, must be dropped
         op = 4'd1; on_carry = 1'b1; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (L) @(negedge clk);
      end else begin
         repeat (L + 1) @(negedge clk);
      end
      m_cy = cy;
      m_mem[adr] = nb;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]   = i[0] ^ i[3] ^ i[5];
         m_mem[i] = mem[i];
      end
      m_cy = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk(carry == 1'b0, 1, carry, 0);
      chk(busy == 1'b0, 1, busy, 0);
      chk(done == 1'b0, 1, done, 0);
      chk(bus_re == 1'b0 && bus_we == 1'b0, 1, {bus_re, bus_we}, 0);
      @(negedge clk);

      // R2 carry-only ops
      run_op(1, 1, 0, 0, 0, 0, 1'b0);
      run_op(2, 1, 0, 0, 0, 0, 1'b0);
      run_op(2, 1, 1, 1, 2, 0, 1'b0);
      run_op(0, 1, 0, 0, 0, 0, 1'b0);

      // R3 R4 R5 R6 R7 R8: every op across form, mode and region
      for (int o = 0; o <= 8; o++)
         for (int oc = 0; oc <= ((o <= 2) ? 1 : 0); oc++)
            for (int ex = 0; ex <= 1; ex++)
               for (int sr = 0; sr <= 1; sr++)
                  for (int rg = 0; rg <= 3; rg++)
                     run_op(o, oc, ex, sr, rg, (o * 37 + oc * 19 + ex * 11 + sr * 5 + rg * 3) & 255, 1'b0);

      // R11: start while busy on a long write op
      run_op(1, 1, 0, 0, 0, 0, 1'b0);
      run_op(0, 0, 1, 0, 2, 77, 1'b1);
      run_op(0, 1, 0, 0, 0, 0, 1'b0);
      run_op(5, 0, 1, 0, 3, 78, 1'b1);
      chk(carry == m_cy, 11, carry, m_cy);

      // R12: undefined op codes are dropped
      op = 4'd12; on_carry = 1'b0; bit_addr = 8'd40; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b0, 12, busy, 0);
      op = 4'd15; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, 12, busy, 0);
      chk(carry == m_cy, 12, carry, m_cy);
      chk(mem[40] == m_mem[40], 12, mem[40], m_mem[40]);

      // R13: reset in the middle of a bit write
      run_op(1, 1, 0, 0, 0, 0, 1'b0);
      op = 4'd8; on_carry = 1'b0; ext_form = 1'b1; src_mode = 1'b0;
      region = 2'd2; bit_addr = 8'd90; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      re_cnt = 0;
      m_cy = 1'b0;
      chk(busy == 1'b0, 13, busy, 0);
      chk(carry == 1'b0, 13, carry, 0);
      repeat (8) @(negedge clk);
      chk(mem[90] == m_mem[90], 13, mem[90], m_mem[90]);
      run_op(7, 0, 0, 0, 1, 90, 1'b0);
      @(negedge clk);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule